// File: doc/BRIEF.md
# Global-Stall Pipeline Handshake Controller

This block supervises a fixed-depth data pipeline whose stage registers live outside it and all share a single advance enable. The block carries no data. It keeps one valid bit per stage and shifts that chain in step with the external registers. It takes an upstream valid/ready handshake and drives a downstream valid/ready handshake.

The whole pipeline either advances together or stalls together. It advances when the output slot is empty or is being consumed. Empty slots (bubbles) travel through the pipeline unchanged and are never collapsed. A chip-enable input freezes the pipeline without affecting the ready that is offered upstream. The reset polarity is a parameter, and reset is synchronous.

Top module: `pipe_stall_ctrl`

## Requirements
- R1: While reset is active at a rising edge, every valid bit is cleared. After reset, `dn_valid` is 0, `up_ready` is 1, and `adv_en` equals `ce`.
- R2: `up_ready` is combinationally 1 exactly when `dn_ready` is 1 or `dn_valid` is 0.
- R3: `adv_en` is 1 exactly when `up_ready` and `ce` are both 1.
- R4: An item is accepted on an edge where `up_valid`, `up_ready` and `ce` are all 1. It shows as `dn_valid` = 1 after exactly DEPTH advancing edges.
- R5: While `ce` is 0, the valid chain holds its value and `adv_en` is 0. `up_ready` still follows R2.
- R6: While `dn_valid` is 1 and `dn_ready` is 0, the pipeline stalls: `up_ready` and `adv_en` are 0, and `dn_valid` stays 1.
- R7: An advancing edge with `up_valid` at 0 inserts an empty slot. The gaps between items at the output equal the gaps at the input.
- R8: Under random `up_valid`, `dn_ready` and `ce`, items leave the pipeline in order, with none lost and none duplicated. Stage registers are modelled as shifting on `adv_en`, and an item is consumed when `dn_valid`, `dn_ready` and `ce` are all 1.
- R9: With `RST_ACTIVE_HIGH` = 0, reset is active while `rst` is 0, and the chain stays cleared even when `up_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, polarity set by `RST_ACTIVE_HIGH` |
| ce | input | 1 | Chip enable, active high |
| up_valid | input | 1 | Upstream data valid |
| up_ready | output | 1 | Pipeline can take an item |
| dn_valid | output | 1 | Last stage holds valid data |
| dn_ready | input | 1 | Downstream can take the output item |
| adv_en | output | 1 | Shared advance enable for the external stage registers |

## Verification
A single isolated item measures the fill latency. An alternating item/gap train shows whether bubbles are kept or collapsed. Back-pressure with a held output and a frozen chip enable separates a stall caused by the consumer from a freeze caused by `ce`. A long random run of all three inputs, checked against a token shift register driven by `adv_en`, exposes any loss, duplication or reordering. A second instance with active-low reset confirms the polarity parameter.

// File: rtl/pipe_stall_ctrl.sv
module pipe_stall_ctrl #(
  parameter int DEPTH = 3,
  parameter bit RST_ACTIVE_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic up_valid,
  output logic up_ready,
  output logic dn_valid,
  input  logic dn_ready,
  output logic adv_en
);
  logic [DEPTH-1:0] vld;
  logic rst_act;
  logic go;

  assign rst_act  = RST_ACTIVE_HIGH ? rst : ~rst;
  assign go       = dn_ready | ~vld[DEPTH-1];
  assign up_ready = go;
  assign adv_en   = go & ce;
  assign dn_valid = vld[DEPTH-1];

  always_ff @(posedge clk) begin
    if (rst_act) begin
      vld <= '0;
    end else if (adv_en) begin
      vld[0] <= up_valid;
      for (int i = 1; i < DEPTH; i++) vld[i] <= vld[i-1];
    end
  end
endmodule

module pipe_stall_ctrl_chk #(
  parameter int DEPTH = 3,
  parameter bit RST_ACTIVE_HIGH = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic ce,
  input logic up_valid,
  input logic up_ready,
  input logic dn_valid,
  input logic dn_ready,
  input logic adv_en,
  input logic [DEPTH-1:0] vld
);
  logic rst_act;
  logic rst_q;
  assign rst_act = RST_ACTIVE_HIGH ? rst : ~rst;

  always @(posedge clk) begin
    if (rst_q === 1'b1) begin
      p_clear_r1: assert (vld == '0) else $error("valid chain not cleared by reset");
    end
    rst_q <= rst_act;
  end

  p_gate_r3: assert property (@(posedge clk) disable iff (rst_act)
    adv_en |-> (ce && up_ready));

  p_first_r4: assert property (@(posedge clk) disable iff (rst_act)
    adv_en |=> vld[0] == $past(up_valid));

  generate
    if (DEPTH > 1) begin : g_chain
      p_chain_r4: assert property (@(posedge clk) disable iff (rst_act)
        adv_en |=> vld[DEPTH-1] == $past(vld[DEPTH-2]));
    end
  endgenerate

  p_hold_r5: assert property (@(posedge clk) disable iff (rst_act)
    !ce |=> $stable(vld));

  p_stall_r6: assert property (@(posedge clk) disable iff (rst_act)
    (dn_valid && !dn_ready) |-> (!up_ready && !adv_en));

  p_keep_r6: assert property (@(posedge clk) disable iff (rst_act)
    (dn_valid && !dn_ready) |=> dn_valid);
endmodule

bind pipe_stall_ctrl pipe_stall_ctrl_chk #(
  .DEPTH(DEPTH), .RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)
) u_chk (
  .clk(clk), .rst(rst), .ce(ce), .up_valid(up_valid), .up_ready(up_ready),
  .dn_valid(dn_valid), .dn_ready(dn_ready), .adv_en(adv_en), .vld(vld)
);

// File: tb/tb_pipe_stall_ctrl.sv
`timescale 1ns/1ps
module tb_pipe_stall_ctrl;
  localparam int DEPTH = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_n = 1'b1;
  logic ce = 1'b0;
  logic up_valid = 1'b0;
  logic dn_ready = 1'b0;
  logic up_ready, dn_valid, adv_en;
  logic up_ready_n, dn_valid_n, adv_en_n;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  pipe_stall_ctrl #(.DEPTH(DEPTH), .RST_ACTIVE_HIGH(1'b1)) dut (
    .clk(clk), .rst(rst), .ce(ce), .up_valid(up_valid), .up_ready(up_ready),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .adv_en(adv_en));

  pipe_stall_ctrl #(.DEPTH(DEPTH), .RST_ACTIVE_HIGH(1'b0)) dut_n (
    .clk(clk), .rst(rst_n), .ce(ce), .up_valid(up_valid), .up_ready(up_ready_n),
    .dn_valid(dn_valid_n), .dn_ready(dn_ready), .adv_en(adv_en_n));

  int tok_in = 0;
  int shreg [DEPTH];
  always @(posedge clk) begin
    if (adv_en) begin
      for (int i = DEPTH - 1; i > 0; i--) shreg[i] <= shreg[i-1];
      shreg[0] <= tok_in;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst = 1'b1; ce = 1'b1; up_valid = 1'b0; dn_ready = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1; ce = 1'b1; up_valid = 1'b1; dn_ready = 1'b0;
    repeat (DEPTH + 2) step();
    chk(dn_valid == 1'b0, "R1 dn_valid in reset", dn_valid, 0);
    rst = 1'b0; up_valid = 1'b0; ce = 1'b0;
    #1;
    chk(up_ready == 1'b1, "R1 up_ready after reset", up_ready, 1);
    chk(adv_en == 1'b0, "R1 adv_en follows ce=0", adv_en, 0);
    ce = 1'b1;
    #1;
    chk(adv_en == 1'b1, "R1 adv_en follows ce=1", adv_en, 1);
  endtask

  task automatic t_latency();
    do_reset();
    up_valid = 1'b1;
    step();
    up_valid = 1'b0;
    for (int k = 2; k <= DEPTH + 1; k++) begin
      if (k < DEPTH + 1) step();
      if (k < DEPTH)
        chk(dn_valid == 1'b0, "R4 early dn_valid", dn_valid, 0);
    end
    chk(dn_valid == 1'b1, "R4 arrival after DEPTH edges", dn_valid, 1);
    step();
    chk(dn_valid == 1'b0, "R4 single item leaves", dn_valid, 0);
  endtask

  task automatic t_stall();
    do_reset();
    dn_ready = 1'b0;
    up_valid = 1'b1;
    step();
    up_valid = 1'b0;
    repeat (DEPTH - 1) step();
    chk(dn_valid == 1'b1, "R6 item at output", dn_valid, 1);
    repeat (4) begin
      chk(up_ready == 1'b0, "R6 up_ready low in stall", up_ready, 0);
      chk(adv_en == 1'b0, "R6 adv_en low in stall", adv_en, 0);
      step();
      chk(dn_valid == 1'b1, "R6 output held", dn_valid, 1);
    end
    dn_ready = 1'b1;
    #1;
    chk(up_ready == 1'b1, "R2 up_ready rises with dn_ready", up_ready, 1);
    chk(adv_en == 1'b1, "R3 adv_en rises with ready and ce", adv_en, 1);
    step();
    chk(dn_valid == 1'b0, "R6 released item consumed", dn_valid, 0);
  endtask

  task automatic t_ce();
    do_reset();
    up_valid = 1'b1;
    step();
    up_valid = 1'b0;
    ce = 1'b0;
    #1;
    chk(adv_en == 1'b0, "R5 adv_en low with ce low", adv_en, 0);
    chk(up_ready == 1'b1, "R5 up_ready follows R2 with ce low", up_ready, 1);
    repeat (4) step();
    chk(dn_valid == 1'b0, "R5 chain frozen", dn_valid, 0);
    ce = 1'b1;
    repeat (DEPTH - 2) step();
    chk(dn_valid == 1'b0, "R5 not yet arrived", dn_valid, 0);
    step();
    chk(dn_valid == 1'b1, "R5 arrival after resume", dn_valid, 1);
    dn_ready = 1'b0; ce = 1'b0;
    #1;
    chk(up_ready == 1'b0, "R5 up_ready low full, ce low", up_ready, 0);
    dn_ready = 1'b1;
    #1;
    chk(up_ready == 1'b1, "R5 up_ready tracks dn_ready, ce low", up_ready, 1);
    chk(adv_en == 1'b0, "R5 adv_en low, ce low", adv_en, 0);
    step();
    chk(dn_valid == 1'b1, "R5 item kept while ce low", dn_valid, 1);
    ce = 1'b1;
  endtask

  task automatic t_bubble();
    bit pat [5] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    bit got [5];
    do_reset();
    for (int k = 0; k < 5 + DEPTH; k++) begin
      up_valid = (k < 5) ? pat[k] : 1'b0;
      step();
      if (k >= DEPTH - 1 && k - (DEPTH - 1) < 5) got[k - (DEPTH - 1)] = dn_valid;
    end
    for (int k = 0; k < 5; k++)
      chk(got[k] == pat[k], "R7 gap pattern preserved", got[k], pat[k]);
  endtask

  task automatic t_random();
    int sent = 0;
    int rcvd = 0;
    do_reset();
    for (int i = 0; i < DEPTH; i++) shreg[i] = -1;
    for (int c = 0; c < 3000 + DEPTH + 4; c++) begin
      @(negedge clk);
      if (c < 3000) begin
        up_valid = ($urandom_range(0, 99) < 60);
        dn_ready = ($urandom_range(0, 99) < 55);
        ce = ($urandom_range(0, 99) < 85);
      end else begin
        up_valid = 1'b0; dn_ready = 1'b1; ce = 1'b1;
      end
      tok_in = sent;
      #1;
      if (dn_valid && dn_ready && ce) begin
        chk(shreg[DEPTH-1] == rcvd, "R8 in-order token", shreg[DEPTH-1], rcvd);
        rcvd++;
      end
      if (up_valid && up_ready && ce) sent++;
    end
    chk(rcvd == sent, "R8 no loss", rcvd, sent);
  endtask

  task automatic t_low_reset();
    rst = 1'b0; rst_n = 1'b0; ce = 1'b1; dn_ready = 1'b1; up_valid = 1'b1;
    repeat (DEPTH + 2) step();
    chk(dn_valid_n == 1'b0, "R9 active-low reset holds chain clear", dn_valid_n, 0);
    rst_n = 1'b1;
    step();
    up_valid = 1'b0;
    repeat (DEPTH - 1) step();
    chk(dn_valid_n == 1'b1, "R9 runs with rst high", dn_valid_n, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_latency();
        t_stall();
        t_ce();
        t_bubble();
        t_random();
        t_low_reset();
      end
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule